// File: doc/BRIEF.md
# GPIO Port Register Bank

A control block for one port of up to 32 general-purpose pins. Software reaches it through a simple single-cycle bus: an address, a write strobe with write data, and read data that follows the address combinationally with no wait states. The block holds per-pin registers for mode select, output drive, output data and wake enable. It also holds two alternate-function selection registers and a group of pad configuration registers that the pad ring uses for pull, drive strength, slew and hysteresis.

The six control registers each have a companion set address and a companion clear address. A one written to a bit of the set address forces that bit to 1, and a one written to the clear address forces it to 0. Zero bits leave the register as it was. Software can therefore change single pins without a read-modify-write sequence. The pin levels pass through a two-stage synchronizer and can be read at a read-only input address.

The register contents drive the pad directly. The outputs are the output value, the driver enable, the GPIO-versus-alternate select, the two alternate-function selects and the wake-enable mask.

Top module: `pinport_ctrl`

## Requirements
- R1: Reset (synchronous, active high) clears every register to 0, except the mode-select register at 0x00, which becomes all ones. After reset, pad_gpio_en is all ones, and pad_oe, pad_out, pad_alt_a, pad_alt_b and wake_en are all zero.
- R2: A write to a base address replaces the whole register in the next cycle. The base addresses are: mode select 0x00 (1 = GPIO, 0 = alternate function), driver enable 0x0C (1 = driving), output data 0x18, wake enable 0x4C, alternate select A 0x68 and alternate select B 0x74 (0 = primary, 1 = secondary).
- R3: For each register in R2, a write to base+0x04 sets to 1 every bit written as 1 and leaves the bits written as 0 unchanged.
- R4: For each register in R2, a write to base+0x08 clears to 0 every bit written as 1 and leaves the bits written as 0 unchanged.
- R5: Reads of any set or clear alias address return 0.
- R6: Address 0x24 returns the pin levels through a two-flop synchronizer. A level present at one clock edge is readable after the second edge that follows it. Writes to 0x24 change no register.
- R7: Reserved and unmapped addresses (for example 0x44, 0x58 and 0x80) read as 0, and writes to them change no register.
- R8: The pad configuration registers at 0x60, 0x64, 0xA8, 0xAC, 0xB0, 0xB4 and 0xB8 are plain read/write 32-bit registers. They have no set or clear aliases, so a write to 0x64 changes 0x64 only.
- R9: Read data depends on the current address alone. In the cycle of a write, a read of the same register returns the value from before that write.
- R10: pad_out, pad_oe, pad_gpio_en, pad_alt_a, pad_alt_b and wake_en equal the output-data, driver-enable, mode-select, alternate-A, alternate-B and wake-enable registers at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 8 | Byte address of the register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for addr |
| pin_in | input | 32 | Pin levels from the pads |
| pad_out | output | 32 | Output value per pin |
| pad_oe | output | 32 | Driver enable per pin |
| pad_gpio_en | output | 32 | 1 = pin in GPIO mode, 0 = alternate function |
| pad_alt_a | output | 32 | Alternate select A (0 primary, 1 secondary) |
| pad_alt_b | output | 32 | Alternate select B (0 primary, 1 secondary) |
| wake_en | output | 32 | Wake enable per pin |

## Verification
Two things can land in the same clock cycle: a write to a register and a read of that same register, because the read path is combinational and the write takes effect at the edge. The bench drives a write to the output-data register and holds the same address. It samples rd_data before the edge, where it must still show the old value, and again after the edge, where it must show the new value. The synchronizer is handled the same way: a pin change is made while the input address is being read, and the old level must hold for one edge before the new one appears.

// File: rtl/pinport_pkg.sv
package pinport_pkg;

    typedef logic [7:0] offs_t;

    // base offsets of the stored registers and the input port
    localparam offs_t OFS_FUNC   = 8'h00;
    localparam offs_t OFS_OUTEN  = 8'h0C;
    localparam offs_t OFS_OUTDAT = 8'h18;
    localparam offs_t OFS_INPUT  = 8'h24;
    localparam offs_t OFS_WAKE   = 8'h4C;
    localparam offs_t OFS_PULL0  = 8'h60;
    localparam offs_t OFS_PULL1  = 8'h64;
    localparam offs_t OFS_ALT_A  = 8'h68;
    localparam offs_t OFS_ALT_B  = 8'h74;
    localparam offs_t OFS_HYST   = 8'hA8;
    localparam offs_t OFS_SLEW   = 8'hAC;
    localparam offs_t OFS_DRV0   = 8'hB0;
    localparam offs_t OFS_DRV1   = 8'hB4;
    localparam offs_t OFS_PSEL   = 8'hB8;

    // distance of the atomic aliases from their base
    localparam offs_t ALIAS_SET = 8'h04;
    localparam offs_t ALIAS_CLR = 8'h08;

    // stored registers first; the aliased ones occupy the lowest ids
    typedef enum logic [3:0] {
        RID_FUNC, RID_OUTEN, RID_OUTDAT, RID_WAKE, RID_ALT_A, RID_ALT_B,
        RID_PULL0, RID_PULL1, RID_HYST, RID_SLEW, RID_DRV0, RID_DRV1, RID_PSEL,
        RID_INPUT, RID_NONE
    } reg_id_e;

    localparam int NUM_STORE   = 13;
    localparam int NUM_ALIASED = 6;

    typedef enum logic [1:0] {OP_NONE, OP_WRITE, OP_SET, OP_CLR} wr_op_e;

    typedef struct packed {
        reg_id_e id;
        wr_op_e  op;
        logic    rd_ok;
    } decode_t;

    function automatic offs_t base_of(input int idx);
        case (idx)
            0:       return OFS_FUNC;
            1:       return OFS_OUTEN;
            2:       return OFS_OUTDAT;
            3:       return OFS_WAKE;
            4:       return OFS_ALT_A;
            5:       return OFS_ALT_B;
            6:       return OFS_PULL0;
            7:       return OFS_PULL1;
            8:       return OFS_HYST;
            9:       return OFS_SLEW;
            10:      return OFS_DRV0;
            11:      return OFS_DRV1;
            12:      return OFS_PSEL;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic decode_t decode_offset(input offs_t a);
        decode_t d;
        d = '{id: RID_NONE, op: OP_NONE, rd_ok: 1'b0};
        for (int i = 0; i < NUM_STORE; i++) begin
            if (a == base_of(i)) begin
                d = '{id: reg_id_e'(i), op: OP_WRITE, rd_ok: 1'b1};
            end else if (i < NUM_ALIASED && a == base_of(i) + ALIAS_SET) begin
                d = '{id: reg_id_e'(i), op: OP_SET, rd_ok: 1'b0};
            end else if (i < NUM_ALIASED && a == base_of(i) + ALIAS_CLR) begin
                d = '{id: reg_id_e'(i), op: OP_CLR, rd_ok: 1'b0};
            end
        end
        if (a == OFS_INPUT) begin
            d = '{id: RID_INPUT, op: OP_NONE, rd_ok: 1'b1};
        end
        return d;
    endfunction

endpackage

// File: rtl/pinport_decode.sv
module pinport_decode
    import pinport_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    offs_t low;
    logic  hi_zero;

    generate
        if (ADDR_W > 8) begin : g_wide
            assign low     = addr[7:0];
            assign hi_zero = (addr[ADDR_W-1:8] == '0);
        end else begin : g_narrow
            assign low     = 8'(addr);
            assign hi_zero = 1'b1;
        end
    endgenerate

    always_comb begin
        if (hi_zero) dec = decode_offset(low);
        else         dec = '{id: RID_NONE, op: OP_NONE, rd_ok: 1'b0};
    end
endmodule

// File: rtl/pinport_reg.sv
module pinport_reg
    import pinport_pkg::*;
#(
    parameter int           W       = 32,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  wr_op_e       op,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST_VAL;
        end else begin
            case (op)
                OP_WRITE: q <= wdata;
                OP_SET:   q <= q | wdata;
                OP_CLR:   q <= q & ~wdata;
                default:  q <= q;
            endcase
        end
    end
endmodule

// File: rtl/pinport_sync.sv
module pinport_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)         stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= d;
                else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pinport_ctrl.sv
module pinport_ctrl
    import pinport_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [NPINS-1:0]  wr_data,
    output logic [NPINS-1:0]  rd_data,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_gpio_en,
    output logic [NPINS-1:0]  pad_alt_a,
    output logic [NPINS-1:0]  pad_alt_b,
    output logic [NPINS-1:0]  wake_en
);
    localparam logic [NPINS-1:0] ALL_ONES  = {NPINS{1'b1}};
    localparam logic [NPINS-1:0] ALL_ZEROS = {NPINS{1'b0}};

    decode_t          dec;
    logic [NPINS-1:0] store_q [NUM_STORE];
    logic [NPINS-1:0] pin_sync;

    pinport_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .dec  (dec)
    );

    generate
        for (genvar g = 0; g < NUM_STORE; g++) begin : g_store
            wr_op_e op_g;
            assign op_g = (wr_en && dec.id == reg_id_e'(g)) ? dec.op : OP_NONE;
            pinport_reg #(
                .W       (NPINS),
                .RST_VAL ((g == int'(RID_FUNC)) ? ALL_ONES : ALL_ZEROS)
            ) u_reg (
                .clk   (clk),
                .rst   (rst),
                .op    (op_g),
                .wdata (wr_data),
                .q     (store_q[g])
            );
        end
    endgenerate

    pinport_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    // combinational read: aliases, reserved holes and misses return zero
    always_comb begin
        rd_data = '0;
        if (dec.rd_ok) begin
            if (dec.id == RID_INPUT) begin
                rd_data = pin_sync;
            end else begin
                for (int i = 0; i < NUM_STORE; i++) begin
                    if (dec.id == reg_id_e'(i)) rd_data = store_q[i];
                end
            end
        end
    end

    assign pad_gpio_en = store_q[RID_FUNC];
    assign pad_oe      = store_q[RID_OUTEN];
    assign pad_out     = store_q[RID_OUTDAT];
    assign wake_en     = store_q[RID_WAKE];
    assign pad_alt_a   = store_q[RID_ALT_A];
    assign pad_alt_b   = store_q[RID_ALT_B];
endmodule

// File: rtl/pinport_ctrl_chk.sv
module pinport_ctrl_chk
    import pinport_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [NPINS-1:0]  wr_data,
    input logic [NPINS-1:0]  rd_data,
    input logic [NPINS-1:0]  pin_in,
    input logic [NPINS-1:0]  pad_out,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  pad_gpio_en,
    input logic [NPINS-1:0]  wake_en
);
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (pad_gpio_en == '1 && pad_oe == '0 && pad_out == '0 && wake_en == '0));

    // R2
    out_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(OFS_OUTDAT)) |=> (pad_out == $past(wr_data)));

    // R3
    set_alias_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(OFS_OUTDAT + ALIAS_SET))
        |=> (pad_out == ($past(pad_out) | $past(wr_data))));

    // R4
    clr_alias_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(OFS_OUTEN + ALIAS_CLR))
        |=> (pad_oe == ($past(pad_oe) & ~$past(wr_data))));

    // R5
    alias_read_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == ADDR_W'(OFS_OUTDAT + ALIAS_SET) || addr == ADDR_W'(OFS_OUTDAT + ALIAS_CLR))
        |-> (rd_data == '0));

    // R6
    input_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == ADDR_W'(OFS_INPUT) && since_rst >= 2'd2) |-> (rd_data == $past(pin_in, 2)));

    // R7
    reserved_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == ADDR_W'(8'h44) || addr == ADDR_W'(8'h58)))
        |=> ($stable(pad_out) && $stable(pad_oe) && $stable(pad_gpio_en) && $stable(wake_en)));
endmodule

bind pinport_ctrl pinport_ctrl_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .addr        (addr),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .pin_in      (pin_in),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .pad_gpio_en (pad_gpio_en),
    .wake_en     (wake_en)
);

// File: tb/pinport_ctrl_bench.sv
module pinport_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [31:0] pin_in = '0;
    logic [31:0] pad_out, pad_oe, pad_gpio_en, pad_alt_a, pad_alt_b, wake_en;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pinport_ctrl u_pinport_ctrl (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_gpio_en(pad_gpio_en), .pad_alt_a(pad_alt_a), .pad_alt_b(pad_alt_b),
        .wake_en(wake_en)
    );

    // {write addr, write data, read addr, expected read, requirement number}
    localparam int NVEC = 22;
    localparam logic [87:0] VEC [NVEC] = '{
        {8'h18, 32'hA5A5_0000, 8'h18, 32'hA5A5_0000, 8'd2},  // R2 output data
        {8'h1C, 32'h0000_00FF, 8'h18, 32'hA5A5_00FF, 8'd3},  // R3
        {8'h20, 32'hA000_000F, 8'h18, 32'h05A5_00F0, 8'd4},  // R4
        {8'h0C, 32'hFFFF_0000, 8'h0C, 32'hFFFF_0000, 8'd2},  // R2 driver enable
        {8'h14, 32'h0F0F_0F0F, 8'h0C, 32'hF0F0_0000, 8'd4},  // R4
        {8'h10, 32'h0000_1234, 8'h0C, 32'hF0F0_1234, 8'd3},  // R3
        {8'h08, 32'h0000_FFFF, 8'h00, 32'hFFFF_0000, 8'd4},  // R4 mode select
        {8'h04, 32'h0000_00F0, 8'h00, 32'hFFFF_00F0, 8'd3},  // R3
        {8'h50, 32'h8000_0001, 8'h4C, 32'h8000_0001, 8'd3},  // R3 wake
        {8'h54, 32'h0000_0001, 8'h4C, 32'h8000_0000, 8'd4},  // R4
        {8'h68, 32'h1357_9BDF, 8'h68, 32'h1357_9BDF, 8'd2},  // R2 alt A
        {8'h78, 32'h0000_0100, 8'h74, 32'h0000_0100, 8'd3},  // R3 alt B
        {8'h7C, 32'h0000_0000, 8'h74, 32'h0000_0100, 8'd4},  // R4 zero bits
        {8'h6C, 32'h0000_0020, 8'h68, 32'h1357_9BFF, 8'd3},  // R3
        {8'hB8, 32'hDEAD_BEEF, 8'hB8, 32'hDEAD_BEEF, 8'd8},  // R8
        {8'h60, 32'h1111_2222, 8'h60, 32'h1111_2222, 8'd8},  // R8
        {8'hA8, 32'hCAFE_F00D, 8'hA8, 32'hCAFE_F00D, 8'd8},  // R8
        {8'h1C, 32'hFFFF_FFFF, 8'h1C, 32'h0000_0000, 8'd5},  // R5 alias reads 0
        {8'h44, 32'hFFFF_FFFF, 8'h44, 32'h0000_0000, 8'd7},  // R7 reserved
        {8'h24, 32'hFFFF_FFFF, 8'h24, 32'h0000_0000, 8'd6},  // R6 write ignored
        {8'h70, 32'h1357_0000, 8'h68, 32'h0000_9BFF, 8'd4},  // R4 alt A clear
        {8'h64, 32'h0000_ABCD, 8'h60, 32'h1111_2222, 8'd8}   // R8 no alias
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_at(input logic [7:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rd_data;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        read_at(8'h00, v);
        check("R1 mode select reset", v, 32'hFFFF_FFFF);
        check("R1 pad_oe reset", pad_oe, 32'h0);
        check("R1 pad_out reset", pad_out, 32'h0);
        read_at(8'hB4, v);
        check("R1 pad config reset", v, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            do_write(VEC[i][87:80], VEC[i][79:48]);
            read_at(VEC[i][47:40], v);
            total++;
            if (v !== VEC[i][39:8]) begin
                bad++;
                $display("FAIL R%0d table step %0d actual=%08h expected=%08h",
                         VEC[i][7:0], i, v, VEC[i][39:8]);
            end
        end

        // R10 pad outputs mirror the registers
        check("R10 pad_out", pad_out, 32'hFFFF_FFFF);
        check("R10 pad_oe", pad_oe, 32'hF0F0_1234);
        check("R10 pad_gpio_en", pad_gpio_en, 32'hFFFF_00F0);
        check("R10 wake_en", wake_en, 32'h8000_0000);
        check("R10 pad_alt_a", pad_alt_a, 32'h0000_9BFF);
        check("R10 pad_alt_b", pad_alt_b, 32'h0000_0100);

        // R6 two-edge synchronizer latency
        @(negedge clk);
        addr = 8'h24;
        pin_in = 32'h1234_5678;
        @(negedge clk);
        check("R6 one edge after pin change", rd_data, 32'h0);
        @(negedge clk);
        check("R6 two edges after pin change", rd_data, 32'h1234_5678);

        // R9 write and read of the same register in one cycle
        @(negedge clk);
        addr = 8'h18; wr_en = 1'b1; wr_data = 32'h0;
        #1;
        check("R9 read in write cycle", rd_data, 32'hFFFF_FFFF);
        @(negedge clk);
        wr_en = 1'b0;
        check("R9 read after write edge", rd_data, 32'h0);

        // R7 write to a reserved hole leaves all state alone
        do_write(8'h58, 32'hFFFF_FFFF);
        check("R7 pad_out after reserved write", pad_out, 32'h0);
        check("R7 pad_oe after reserved write", pad_oe, 32'hF0F0_1234);
        read_at(8'h58, v);
        check("R7 reserved read", v, 32'h0);
        read_at(8'h80, v);
        check("R7 unmapped read", v, 32'h0);

        // R1 reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 pad_gpio_en after reset", pad_gpio_en, 32'hFFFF_FFFF);
        check("R1 pad_oe after reset", pad_oe, 32'h0);
        check("R1 wake_en after reset", wake_en, 32'h0);
        read_at(8'hB8, v);
        check("R1 pad config after reset", v, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule